// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register Front End

This block is the digital side of an eight-channel, 14-bit converter with parallel loading. A host drives an asynchronous bus: a data word, a channel address, an active-low select and an active-low write strobe. The block brings these signals into the system clock domain and detects the end of each qualified write. It then stores the word in the input register of the addressed channel. Each channel has two register ranks. The first rank takes bus writes. The second rank drives the converter code. The second rank is updated only through an active-low load line, which copies every first-rank register at the same time.

If the load line is held low, the second rank follows the first rank. Each write then reaches its channel's code as soon as it is stored. A write that lands in the same cycle as an active load is not lost, because the new word goes to both ranks in that cycle. An active-low clear line asserts a clear indication on every channel at once and without a clock, so the analog stage can switch its outputs to the ground-sense level. Clear changes neither register rank. When clear returns high, the outputs show the stored codes again.

Top module: `dacfe_top`

## Requirements
- R1: After reset, every channel's output code is 0 and no clear indication is asserted while the clear line is high.
- R2: The 3-bit address selects channel index equal to its binary value (0 is the first channel, 7 the last), and a write changes only that channel's input register.
- R3: A write happens only if select and write strobe are both low at the same time. A pulse on one of them while the other stays high stores nothing.
- R4: The stored word is the 14-bit straight binary value (bit 13 MSB, bit 0 LSB) that was present while select and write were both low. The write completes when either line returns high. A change of the data lines at or after that release does not affect the stored word.
- R5: While the load line is high, writes change no output code.
- R6: While the load line is low, all eight DAC registers copy their input registers on the same clock edge.
- R7: The load line, and the end of a write, act on the output codes on the third rising clock edge after the change on the bus. The output is unchanged after the second edge.
- R8: Taking the clear line low sets all eight clear flags at once, with no clock edge needed, and leaves the output codes unchanged.
- R9: Writes and loads keep working while clear is low. When clear goes high, the flags drop and each output shows its current DAC register.
- R10: A write that completes while the load line is low updates the DAC register in the same cycle as the input register, so the written word appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 14 | Parallel data word, straight binary |
| bus_addr | input | 3 | Channel address |
| bus_cs_n | input | 1 | Active-low select |
| bus_wr_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low global transfer to DAC registers |
| clear_n | input | 1 | Active-low asynchronous clear request |
| dac_code | output | 112 | DAC register values, channel k at bits [14k+13:14k] |
| clear_active | output | 8 | Per-channel clear indication, high while clear is requested |

## Verification
Faults in this block show up at the ports in three ways. A wrong input register stays hidden until the next load. A wrong address decode puts the code on the wrong channel. A faulty write-edge detector either loses the word or stores the value seen after release. The bench therefore writes distinct codes to all channels with load high and confirms that no output moves. It then pulses load and compares all eight outputs on the same edge, so a buffered fault becomes visible within three cycles of the load. Latency is checked on exact edges. The transparent mode and the clear path are checked across a write made while clear is active.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   // state of the write-strobe detector
   typedef enum logic {
      WR_IDLE  = 1'b0,
      WR_ARMED = 1'b1
   } wr_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/dacfe_wr_detect.sv
module dacfe_wr_detect
   import dacfe_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              wr_n_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] data_s,
   output logic              qual,
   output logic              strobe,
   output logic [ADDR_W-1:0] addr_h,
   output logic [DATA_W-1:0] data_h
);
   wr_state_e state_q;

   // both lines low: a write is in progress
   assign qual   = !cs_n_s && !wr_n_s;
   // end of a qualified interval: either line went high
   assign strobe = (state_q == WR_ARMED) && !qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WR_IDLE;
         addr_h  <= '0;
         data_h  <= '0;
      end else begin
         state_q <= qual ? WR_ARMED : WR_IDLE;
         if (qual) begin
            addr_h <= addr_s;
            data_h <= data_s;
         end
      end
   end
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
   parameter int unsigned DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [DATA_W-1:0] in_q,
   output logic [DATA_W-1:0] dac_q
);
   logic [DATA_W-1:0] in_next;

   // a write in the load cycle is forwarded to the second rank
   assign in_next = wr_en ? wr_data : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_q <= '0;
      end else begin
         in_q <= in_next;
         if (load) dac_q <= in_next;
      end
   end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
   import dacfe_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned DATA_W      = 14,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned CODE_W     = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_cs_n,
   input  logic              bus_wr_n,
   input  logic              load_n,
   input  logic              clear_n,
   output logic [CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0] clear_active
);
   localparam int unsigned CTRL_W = 3;
   localparam int unsigned PATH_W = ADDR_W + DATA_W;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dacfe_top: NUM_CH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dacfe_top: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("dacfe_top: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_s;
   logic [PATH_W-1:0] path_s;
   logic              cs_n_s, wr_n_s, load_n_s;
   logic [ADDR_W-1:0] addr_s, addr_h;
   logic [DATA_W-1:0] data_s, data_h;
   logic              wr_qual, wr_strobe, load_act;
   logic [NUM_CH-1:0] wr_sel;
   logic [CODE_W-1:0] in_code;

   dacfe_sync #(
      .WIDTH  (CTRL_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL({CTRL_W{1'b1}})
   ) u_sync_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async({bus_cs_n, bus_wr_n, load_n}),
      .q_sync (ctrl_s)
   );

   dacfe_sync #(
      .WIDTH  (PATH_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL('0)
   ) u_sync_path (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async({bus_addr, bus_data}),
      .q_sync (path_s)
   );

   assign {cs_n_s, wr_n_s, load_n_s} = ctrl_s;
   assign {addr_s, data_s}           = path_s;
   assign load_act                   = !load_n_s;

   dacfe_wr_detect #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_wr_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n_s(cs_n_s),
      .wr_n_s(wr_n_s),
      .addr_s(addr_s),
      .data_s(data_s),
      .qual  (wr_qual),
      .strobe(wr_strobe),
      .addr_h(addr_h),
      .data_h(data_h)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(ch);

         assign wr_sel[ch] = wr_strobe && (addr_h == CH_ADDR);

         dacfe_channel #(
            .DATA_W(DATA_W)
         ) u_channel (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_sel[ch]),
            .wr_data(data_h),
            .load   (load_act),
            .in_q   (in_code[ch*DATA_W +: DATA_W]),
            .dac_q  (dac_code[ch*DATA_W +: DATA_W])
         );

         // clear acts without a clock and never touches the ranks
         assign clear_active[ch] = !clear_n;
      end
   endgenerate
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 14,
   localparam int unsigned CODE_W = NUM_CH * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear_n,
   input logic              cs_n_s,
   input logic              wr_n_s,
   input logic              wr_strobe,
   input logic              load_act,
   input logic [NUM_CH-1:0] wr_sel,
   input logic [CODE_W-1:0] in_code,
   input logic [CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0] clear_active
);
   AST_ONE_CHANNEL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel)); // R2

   AST_WRITE_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(!cs_n_s && !wr_n_s)); // R3

   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> $stable(dac_code)); // R5

   AST_LOAD_COPIES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (load_act && !wr_strobe) |=> (dac_code == in_code)); // R6

   AST_WRITE_THROUGH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_act && wr_strobe) |=> (dac_code == in_code)); // R10

   AST_CLEAR_ALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n |-> (&clear_active)); // R8

   AST_NO_FLAG_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear_n |-> (clear_active == '0)); // R9
endmodule

bind dacfe_top dacfe_checker #(
   .NUM_CH(NUM_CH),
   .DATA_W(DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear_n     (clear_n),
   .cs_n_s      (cs_n_s),
   .wr_n_s      (wr_n_s),
   .wr_strobe   (wr_strobe),
   .load_act    (load_act),
   .wr_sel      (wr_sel),
   .in_code     (in_code),
   .dac_code    (dac_code),
   .clear_active(clear_active)
);

// File: tb/dacfe_top_tb.sv
module dacfe_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [DW-1:0]   bus_data = '0;
   logic [2:0]      bus_addr = '0;
   logic            bus_cs_n = 1'b1;
   logic            bus_wr_n = 1'b1;
   logic            load_n = 1'b1;
   logic            clear_n = 1'b1;
   logic [NCH*DW-1:0] dac_code;
   logic [NCH-1:0]  clear_active;

   int n_cmp = 0;
   int n_bad = 0;
   logic [DW-1:0] exp_dac [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   dacfe_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
      .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .load_n(load_n),
      .clear_n(clear_n), .dac_code(dac_code), .clear_active(clear_active)
   );

   function automatic logic [DW-1:0] code_of(int ch);
      return dac_code[ch*DW +: DW];
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      for (int c = 0; c < NCH; c++) chk(req, code_of(c), exp_dac[c]);
   endtask

   // write with select and strobe low together; data cleared at release
   task automatic bus_write(logic [2:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_data = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      bus_wr_n = 1'b1; bus_data = '0;
      @(negedge clk);
      bus_cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic load_pulse();
      @(negedge clk); load_n = 1'b0;
      repeat (2) @(negedge clk); load_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk_all("R1 reset code");
      chk("R1 no clear flag", DW'(clear_active), '0);
   endtask

   task automatic t_buffered();
      logic [DW-1:0] vals [NCH];
      vals[0] = 14'h3FFF; vals[1] = 14'h2000; vals[2] = 14'h1FFF; vals[3] = 14'h0001;
      vals[4] = 14'h1234; vals[5] = 14'h2A5A; vals[6] = 14'h0F0F; vals[7] = 14'h3C3C;
      for (int c = 0; c < NCH; c++) begin
         bus_write(3'(c), vals[c]);
         chk_all("R5 no output change with load high");
      end
      @(negedge clk); load_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_all("R7 unchanged after second edge");
      @(negedge clk);
      for (int c = 0; c < NCH; c++) exp_dac[c] = vals[c];
      chk_all("R6 all channels on same edge / R2 R4 decode and data");
      load_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_ignored();
      @(negedge clk);
      bus_addr = 3'd0; bus_data = 14'h0AAA; bus_cs_n = 1'b1; bus_wr_n = 1'b0;
      repeat (3) @(negedge clk); bus_wr_n = 1'b1;
      repeat (2) @(negedge clk); bus_cs_n = 1'b0;
      repeat (3) @(negedge clk); bus_cs_n = 1'b1;
      repeat (4) @(negedge clk);
      load_pulse();
      chk("R3 strobe or select alone stores nothing", code_of(0), exp_dac[0]);
   endtask

   task automatic t_transparent();
      @(negedge clk); load_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_addr = 3'd5; bus_data = 14'h15A5; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      bus_wr_n = 1'b1; bus_data = 14'h3333;
      @(negedge clk);
      chk("R7 unchanged after first edge", code_of(5), exp_dac[5]);
      @(negedge clk);
      chk("R7 unchanged after second edge", code_of(5), exp_dac[5]);
      @(negedge clk);
      exp_dac[5] = 14'h15A5;
      chk("R10 write during load reaches output / R4 post-release data ignored",
          code_of(5), exp_dac[5]);
      bus_cs_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_write(3'd7, 14'h0777);
      exp_dac[7] = 14'h0777;
      chk("R10 transparent write last channel", code_of(7), exp_dac[7]);
      @(negedge clk); load_n = 1'b1;
      repeat (4) @(negedge clk);
      chk_all("R2 other channels untouched");
   endtask

   task automatic t_clear();
      @(negedge clk);
      clear_n = 1'b0;
      #1;
      chk("R8 flags without clock", DW'(clear_active), DW'({NCH{1'b1}}));
      chk_all("R8 codes unchanged by clear");
      bus_write(3'd1, 14'h2468);
      load_pulse();
      exp_dac[1] = 14'h2468;
      chk("R8 flags held", DW'(clear_active), DW'({NCH{1'b1}}));
      clear_n = 1'b1;
      #1;
      chk("R9 flags drop", DW'(clear_active), '0);
      chk_all("R9 outputs show DAC registers after clear");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) exp_dac[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_buffered();
      t_ignored();
      t_transparent();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule